// File: doc/BRIEF.md
# Instruction Fetch Stage Controller

This block is the control core of the fetch stage in an out-of-order processor. Each cycle it looks at three kinds of input. The first is redirect requests from the commit and decode stages. The second is the flags that later pipeline stages use to hold it back. The third is the cache and translation response to its own line request. From these it decides whether the stage fetches, waits or changes course. It holds the fetch address and the sequential address after it. It issues one aligned cache-line read per fetch attempt and tells the cache when an outstanding miss is no longer wanted.

Every cycle resolves to one action in a fixed priority order, highest first:

1. A commit redirect.
2. The reorder buffer still unwinding.
3. A decode redirect.
4. Any stall flag.
5. The state-specific step.

The controller has six states:

- Idle: entered at reset. It fetches like Running.
- Running: normal fetching.
- Squashing: a redirect is in progress.
- Blocked: held by a stall flag or by a fault.
- MissWait: the line request missed and the fill is outstanding.
- MissReady: the fill has arrived.

The named transitions are:

- any state → Squashing on a commit redirect, on the reorder-buffer flag, or on a decode redirect taken outside Squashing;
- any state → Blocked on a stall flag;
- Blocked → Running once the stall flags clear, with no fetch in that cycle;
- Squashing, Idle or Running → Running on a hit, fetching in that same cycle;
- Idle, Running or Squashing → MissWait on a miss;
- Idle, Running or Squashing → Blocked on a fault;
- MissWait → MissReady on the fill pulse;
- MissReady → Running, delivering the filled line without a new request.

The cache answers a line request in the same cycle, with a hit, a miss or a translation fault. A fetch delivers the instructions from the current address up to the end of its cache line, and never more than the fetch width. The address then advances past them.

Top module: `fetch_ctl`

## Requirements
- R1: During and after reset, the state output reads Idle and the fetch address equals RESET_PC. State codes: Idle=0, Running=1, Squashing=2, Blocked=3, MissWait=4, MissReady=5.
- R2: A commit redirect wins over every other input. In that cycle no line request and no fetch occur. In the next cycle the state is Squashing and the fetch address is the commit redirect address.
- R3: While the reorder-buffer flag is high and there is no commit redirect, there is no line request and no fetch. The next state is Squashing and the fetch address is unchanged.
- R4: A decode redirect outside Squashing takes effect only when neither the commit redirect nor the reorder-buffer flag is high. It loads the decode redirect address and enters Squashing. In Squashing a decode redirect is ignored, and the address is not loaded.
- R5: Any high stall bit, with no redirect taken, gives no request and no fetch in that cycle. The next state is Blocked and the address is held.
- R6: In Blocked with no redirect and no stall, the cycle issues no request and no fetch, and the next state is Running.
- R7: In Idle, Running or Squashing with nothing pending, line_req is high and line_addr is the fetch address with its low log2(LINE_BYTES) bits cleared. On a hit, fetch_en is high and the next state is Running.
- R8: The fetch count is min(FETCH_W, (LINE_BYTES - address offset within the line)/4). A fetch advances the address by 4 times that count.
- R9: A miss on the request enters MissWait with the address held and no fetch. No request is issued in MissWait or MissReady. fill_done in MissWait leads to MissReady. MissReady fetches without a request and then goes to Running.
- R10: In a cycle that leaves MissWait for any state other than MissReady, miss_cancel is high. A fill_done pulse after that has no effect.
- R11: A translation fault on the request enters Blocked with the address held and no fetch. The fault takes priority over a miss.
- R12: next_pc always equals the fetch address plus 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmt_squash | input | 1 | Redirect request from commit |
| cmt_pc | input | AW | Commit redirect address |
| dec_squash | input | 1 | Redirect request from decode |
| dec_pc | input | AW | Decode redirect address |
| rob_squashing | input | 1 | Reorder buffer still unwinding |
| stall_vec | input | NSTALL | Stall flags (decode, rename, issue/execute, commit) |
| ic_miss | input | 1 | Line request missed this cycle |
| xlate_fault | input | 1 | Line request faulted in translation or read |
| fill_done | input | 1 | Outstanding miss has been filled |
| pc | output | AW | Current fetch address |
| next_pc | output | AW | Fetch address plus one instruction |
| line_req | output | 1 | Cache-line read request this cycle |
| line_addr | output | AW | Line-aligned request address |
| fetch_en | output | 1 | Instructions delivered this cycle |
| fetch_cnt | output | CNTW | Number of instructions delivered |
| miss_cancel | output | 1 | Drop the outstanding miss |
| fst | output | 3 | Current state code |

## Verification
The hardest situation to reach is a fill pulse that arrives after its miss has already been abandoned. The controller must first be in MissWait, then leave it through a redirect or a stall, and only then see fill_done. The bench gets there in three steps. It provokes a miss with ic_miss during a request cycle. It then applies a commit redirect, and in a second run a stall, while the miss is still outstanding. It pulses fill_done in the following cycle and checks that the controller fetches from the new address, or unblocks, instead of entering MissReady.

// File: rtl/fetch_ctl_pkg.sv
package fetch_ctl_pkg;

    typedef enum logic [2:0] {
        FS_IDLE   = 3'd0,
        FS_RUN    = 3'd1,
        FS_SQUASH = 3'd2,
        FS_BLOCK  = 3'd3,
        FS_MWAIT  = 3'd4,
        FS_MREADY = 3'd5
    } fstate_e;

    typedef enum logic [1:0] {
        PC_HOLD = 2'd0,
        PC_CMT  = 2'd1,
        PC_DEC  = 2'd2,
        PC_ADV  = 2'd3
    } pc_op_e;

endpackage

// File: rtl/fetch_ctl_span.sv
// Works out the aligned line address and how many instructions are left
// before the line end, capped at the fetch width.
module fetch_ctl_span #(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 64,
    parameter int FETCH_W    = 4,
    parameter int INST_B     = 4,
    localparam int OFFW      = $clog2(LINE_BYTES),
    localparam int CNTW      = $clog2(FETCH_W + 1)
) (
    input  logic [AW-1:0]   pc,
    output logic [AW-1:0]   line_addr,
    output logic [CNTW-1:0] cnt
);

    logic [OFFW:0] left_b;
    logic [OFFW:0] left_i;

    assign line_addr = {pc[AW-1:OFFW], {OFFW{1'b0}}};

    always_comb begin
        left_b = (OFFW+1)'(LINE_BYTES) - {1'b0, pc[OFFW-1:0]};
        left_i = left_b / (OFFW+1)'(INST_B);
        if (int'(left_i) > FETCH_W) begin
            cnt = CNTW'(FETCH_W);
        end else begin
            cnt = CNTW'(left_i);
        end
    end

endmodule

// File: rtl/fetch_ctl_pc.sv
// Fetch address register pair: current address and sequential successor.
module fetch_ctl_pc
    import fetch_ctl_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          INST_B   = 4,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pc_op_e        op,
    input  logic [AW-1:0] cmt_pc,
    input  logic [AW-1:0] dec_pc,
    input  logic [AW-1:0] adv_bytes,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] next_pc
);

    logic [AW-1:0] target;

    always_comb begin
        unique case (op)
            PC_CMT:  target = cmt_pc;
            PC_DEC:  target = dec_pc;
            PC_ADV:  target = pc + adv_bytes;
            default: target = pc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc      <= RESET_PC;
            next_pc <= RESET_PC + AW'(INST_B);
        end else if (op != PC_HOLD) begin
            pc      <= target;
            next_pc <= target + AW'(INST_B);
        end
    end

endmodule

// File: rtl/fetch_ctl.sv
module fetch_ctl
    import fetch_ctl_pkg::*;
#(
    parameter int            AW         = 32,
    parameter int            LINE_BYTES = 64,
    parameter int            FETCH_W    = 4,
    parameter int            NSTALL     = 4,
    parameter logic [AW-1:0] RESET_PC   = '0,
    localparam int           INST_B     = 4,
    localparam int           IB_SH      = $clog2(INST_B),
    localparam int           CNTW       = $clog2(FETCH_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmt_squash,
    input  logic [AW-1:0]     cmt_pc,
    input  logic              dec_squash,
    input  logic [AW-1:0]     dec_pc,
    input  logic              rob_squashing,
    input  logic [NSTALL-1:0] stall_vec,
    input  logic              ic_miss,
    input  logic              xlate_fault,
    input  logic              fill_done,
    output logic [AW-1:0]     pc,
    output logic [AW-1:0]     next_pc,
    output logic              line_req,
    output logic [AW-1:0]     line_addr,
    output logic              fetch_en,
    output logic [CNTW-1:0]   fetch_cnt,
    output logic              miss_cancel,
    output logic [2:0]        fst
);

    fstate_e       st, st_n;
    pc_op_e        op;
    logic          any_stall;
    logic [AW-1:0] adv_bytes;

    assign any_stall = |stall_vec;
    assign fst       = st;
    assign adv_bytes = AW'(fetch_cnt) << IB_SH;

    fetch_ctl_span #(
        .AW(AW), .LINE_BYTES(LINE_BYTES), .FETCH_W(FETCH_W), .INST_B(INST_B)
    ) u_span (
        .pc        (pc),
        .line_addr (line_addr),
        .cnt       (fetch_cnt)
    );

    fetch_ctl_pc #(
        .AW(AW), .INST_B(INST_B), .RESET_PC(RESET_PC)
    ) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .cmt_pc    (cmt_pc),
        .dec_pc    (dec_pc),
        .adv_bytes (adv_bytes),
        .pc        (pc),
        .next_pc   (next_pc)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= FS_IDLE;
        end else begin
            st <= st_n;
        end
    end

    // Priority resolution, next state and outputs
    always_comb begin
        st_n     = st;
        op       = PC_HOLD;
        line_req = 1'b0;
        fetch_en = 1'b0;
        if (cmt_squash) begin
            st_n = FS_SQUASH;
            op   = PC_CMT;
        end else if (rob_squashing) begin
            st_n = FS_SQUASH;
        end else if (dec_squash && st != FS_SQUASH) begin
            st_n = FS_SQUASH;
            op   = PC_DEC;
        end else if (any_stall) begin
            st_n = FS_BLOCK;
        end else begin
            unique case (st)
                FS_BLOCK: begin
                    st_n = FS_RUN;
                end
                FS_MWAIT: begin
                    if (fill_done) begin
                        st_n = FS_MREADY;
                    end
                end
                FS_MREADY: begin
                    fetch_en = 1'b1;
                    op       = PC_ADV;
                    st_n     = FS_RUN;
                end
                default: begin
                    line_req = 1'b1;
                    if (xlate_fault) begin
                        st_n = FS_BLOCK;
                    end else if (ic_miss) begin
                        st_n = FS_MWAIT;
                    end else begin
                        fetch_en = 1'b1;
                        op       = PC_ADV;
                        st_n     = FS_RUN;
                    end
                end
            endcase
        end
        miss_cancel = (st == FS_MWAIT) && (st_n != FS_MWAIT) && (st_n != FS_MREADY);
    end

endmodule

// File: rtl/fetch_ctl_chk.sv
module fetch_ctl_chk
    import fetch_ctl_pkg::*;
#(
    parameter int AW      = 32,
    parameter int FETCH_W = 4,
    parameter int NSTALL  = 4,
    parameter int CNTW    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmt_squash,
    input logic [AW-1:0]     cmt_pc,
    input logic              dec_squash,
    input logic              rob_squashing,
    input logic [NSTALL-1:0] stall_vec,
    input logic [AW-1:0]     pc,
    input logic [AW-1:0]     next_pc,
    input logic              line_req,
    input logic              fetch_en,
    input logic [CNTW-1:0]   fetch_cnt,
    input logic              miss_cancel,
    input logic [2:0]        fst
);

    a_r2_commit_first: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_squash |=> (fst == FS_SQUASH) && (pc == $past(cmt_pc)));

    a_r2_commit_nofetch: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_squash |-> !line_req && !fetch_en);

    a_r3_rob_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rob_squashing && !cmt_squash) |=> (fst == FS_SQUASH) && $stable(pc));

    a_r5_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ((|stall_vec) && !cmt_squash && !rob_squashing && !dec_squash)
        |=> (fst == FS_BLOCK) && $stable(pc));

    a_r6_unblock_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (fst == FS_BLOCK) |-> !line_req && !fetch_en);

    a_r9_no_req_in_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (fst == FS_MWAIT || fst == FS_MREADY) |-> !line_req);

    a_r10_cancel_exit: assert property (@(posedge clk) disable iff (!rst_n)
        miss_cancel |-> (fst == FS_MWAIT) ##1 (fst != FS_MWAIT && fst != FS_MREADY));

    a_r12_seq_addr: assert property (@(posedge clk) disable iff (!rst_n)
        next_pc == pc + AW'(4));

    a_r8_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en |-> (fetch_cnt != '0) && (int'(fetch_cnt) <= FETCH_W));

endmodule

bind fetch_ctl fetch_ctl_chk #(
    .AW(AW), .FETCH_W(FETCH_W), .NSTALL(NSTALL), .CNTW(CNTW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmt_squash    (cmt_squash),
    .cmt_pc        (cmt_pc),
    .dec_squash    (dec_squash),
    .rob_squashing (rob_squashing),
    .stall_vec     (stall_vec),
    .pc            (pc),
    .next_pc       (next_pc),
    .line_req      (line_req),
    .fetch_en      (fetch_en),
    .fetch_cnt     (fetch_cnt),
    .miss_cancel   (miss_cancel),
    .fst           (fst)
);

// File: tb/tb_fetch_ctl.sv
`timescale 1ns/100ps
module tb_fetch_ctl;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cmt_squash, dec_squash, rob_squashing;
    logic [AW-1:0] cmt_pc, dec_pc;
    logic [3:0]    stall_vec;
    logic          ic_miss, xlate_fault, fill_done;
    logic [AW-1:0] pc, next_pc, line_addr;
    logic          line_req, fetch_en, miss_cancel;
    logic [2:0]    fetch_cnt;
    logic [2:0]    fst;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    fetch_ctl dut (
        .clk(clk), .rst_n(rst_n),
        .cmt_squash(cmt_squash), .cmt_pc(cmt_pc),
        .dec_squash(dec_squash), .dec_pc(dec_pc),
        .rob_squashing(rob_squashing), .stall_vec(stall_vec),
        .ic_miss(ic_miss), .xlate_fault(xlate_fault), .fill_done(fill_done),
        .pc(pc), .next_pc(next_pc), .line_req(line_req), .line_addr(line_addr),
        .fetch_en(fetch_en), .fetch_cnt(fetch_cnt), .miss_cancel(miss_cancel),
        .fst(fst)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clr_in();
        cmt_squash = 0; dec_squash = 0; rob_squashing = 0;
        cmt_pc = '0; dec_pc = '0; stall_vec = '0;
        ic_miss = 0; xlate_fault = 0; fill_done = 0;
    endtask

    // Advance one clock; returns at the following falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic chk_regs(input string req, input logic [2:0] s, input logic [31:0] p);
        chk(req, "state", 32'(fst), 32'(s));
        chk(req, "pc", pc, p);
        chk("R12", "next_pc", next_pc, p + 32'd4);
    endtask

    task automatic t_reset();
        clr_in();
        rst_n = 0;
        repeat (3) tick();
        chk_regs("R1", 3'd0, 32'h0);
        rst_n = 1;
        settle();
        chk_regs("R1", 3'd0, 32'h0);
    endtask

    task automatic t_hit();
        // Idle with nothing pending fetches from address 0, full width
        chk("R7", "line_req", 32'(line_req), 1);
        chk("R7", "line_addr", line_addr, 32'h0);
        chk("R7", "fetch_en", 32'(fetch_en), 1);
        chk("R8", "fetch_cnt", 32'(fetch_cnt), 4);
        tick();
        chk_regs("R8", 3'd1, 32'h10);
    endtask

    task automatic t_commit_wins();
        cmt_squash = 1; cmt_pc = 32'h38;
        dec_squash = 1; dec_pc = 32'h200;
        rob_squashing = 1; stall_vec = 4'hF; ic_miss = 1;
        settle();
        chk("R2", "line_req", 32'(line_req), 0);
        chk("R2", "fetch_en", 32'(fetch_en), 0);
        tick();
        clr_in();
        chk_regs("R2", 3'd2, 32'h38);
    endtask

    task automatic t_squash_exit_line_end();
        // In Squashing: decode redirect ignored, fetch proceeds, 2 slots to line end
        dec_squash = 1; dec_pc = 32'h200;
        settle();
        chk("R4", "line_req", 32'(line_req), 1);
        chk("R7", "line_addr", line_addr, 32'h0);
        chk("R7", "fetch_en", 32'(fetch_en), 1);
        chk("R8", "fetch_cnt", 32'(fetch_cnt), 2);
        tick();
        clr_in();
        chk_regs("R4", 3'd1, 32'h40);
    endtask

    task automatic t_decode_redirect();
        dec_squash = 1; dec_pc = 32'h134;
        settle();
        chk("R4", "fetch_en", 32'(fetch_en), 0);
        tick();
        clr_in();
        chk_regs("R4", 3'd2, 32'h134);
        settle();
        chk("R8", "fetch_cnt", 32'(fetch_cnt), 3);
        chk("R7", "line_addr", line_addr, 32'h100);
        tick();
        chk_regs("R8", 3'd1, 32'h140);
    endtask

    task automatic t_rob();
        for (int i = 0; i < 2; i++) begin
            rob_squashing = 1;
            dec_squash = (i == 1); dec_pc = 32'h500;
            settle();
            chk("R3", "line_req", 32'(line_req), 0);
            chk("R3", "fetch_en", 32'(fetch_en), 0);
            tick();
            chk_regs("R3", 3'd2, 32'h140);
        end
        clr_in();
        tick();
        chk_regs("R3", 3'd1, 32'h150);
    endtask

    task automatic t_stall();
        for (int i = 0; i < 4; i++) begin
            stall_vec = 4'(1 << i);
            settle();
            chk("R5", "line_req", 32'(line_req), 0);
            tick();
            chk_regs("R5", 3'd3, 32'h150);
        end
        clr_in();
        settle();
        chk("R6", "line_req", 32'(line_req), 0);
        chk("R6", "fetch_en", 32'(fetch_en), 0);
        tick();
        chk_regs("R6", 3'd1, 32'h150);
        tick();
        chk_regs("R6", 3'd1, 32'h160);
    endtask

    task automatic t_miss();
        ic_miss = 1;
        settle();
        chk("R9", "line_req", 32'(line_req), 1);
        chk("R9", "fetch_en", 32'(fetch_en), 0);
        tick();
        clr_in();
        chk_regs("R9", 3'd4, 32'h160);
        for (int i = 0; i < 2; i++) begin
            settle();
            chk("R9", "line_req", 32'(line_req), 0);
            chk("R10", "miss_cancel", 32'(miss_cancel), 0);
            tick();
            chk_regs("R9", 3'd4, 32'h160);
        end
        fill_done = 1;
        settle();
        chk("R9", "fetch_en", 32'(fetch_en), 0);
        tick();
        clr_in();
        chk_regs("R9", 3'd5, 32'h160);
        settle();
        chk("R9", "line_req", 32'(line_req), 0);
        chk("R9", "fetch_en", 32'(fetch_en), 1);
        chk("R9", "fetch_cnt", 32'(fetch_cnt), 4);
        tick();
        chk_regs("R9", 3'd1, 32'h170);
    endtask

    task automatic t_cancel();
        ic_miss = 1;
        tick();
        clr_in();
        chk_regs("R10", 3'd4, 32'h170);
        cmt_squash = 1; cmt_pc = 32'h3F8;
        settle();
        chk("R10", "miss_cancel", 32'(miss_cancel), 1);
        tick();
        clr_in();
        chk_regs("R10", 3'd2, 32'h3F8);
        fill_done = 1;
        settle();
        chk("R10", "miss_cancel", 32'(miss_cancel), 0);
        chk("R10", "line_req", 32'(line_req), 1);
        chk("R10", "fetch_cnt", 32'(fetch_cnt), 2);
        tick();
        clr_in();
        chk_regs("R10", 3'd1, 32'h400);
        // Second run: a stall abandons the miss, a late fill is ignored
        ic_miss = 1;
        tick();
        clr_in();
        stall_vec = 4'b0100;
        settle();
        chk("R10", "miss_cancel", 32'(miss_cancel), 1);
        tick();
        clr_in();
        chk_regs("R10", 3'd3, 32'h400);
        fill_done = 1;
        settle();
        chk("R10", "fetch_en", 32'(fetch_en), 0);
        tick();
        clr_in();
        chk_regs("R10", 3'd1, 32'h400);
    endtask

    task automatic t_fault();
        xlate_fault = 1; ic_miss = 1;
        settle();
        chk("R11", "line_req", 32'(line_req), 1);
        chk("R11", "fetch_en", 32'(fetch_en), 0);
        tick();
        clr_in();
        chk_regs("R11", 3'd3, 32'h400);
        tick();
        chk_regs("R11", 3'd1, 32'h400);
        tick();
        chk_regs("R11", 3'd1, 32'h410);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_hit();
        t_commit_wins();
        t_squash_exit_line_end();
        t_decode_redirect();
        t_rob();
        t_stall();
        t_miss();
        t_cancel();
        t_fault();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule